// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM refreshed and brings it out of power-up. After reset it stays silent for a programmable pause. It then asks the access controller for the bus and issues a fixed number of initial refresh cycles. Once those are done it raises a sticky ready flag. From then on an interval timer adds one owed refresh per period. The period is the refresh window divided by the number of rows.

Every refresh is a CAS-before-RAS cycle. The memory's own row counter picks the row, so no address is driven. The block drives the RAS and CAS strobes itself while it owns the bus. Write enable is held high throughout, because a refresh with write enable low would put the memory into a test state.

Owed refreshes accumulate in a saturating counter, so refreshes that the controller defers are not lost. If the request and the grant are both still present at the end of a precharge, the next refresh follows without handing the bus back. All timing is given in nanoseconds and rounded up to whole clock cycles.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted, `req_o`, `own_o` and `init_done_o` are 0, and `ras_n_o`, `cas_n_o` and `we_n_o` are 1.
- R2: `req_o` stays 0 for the first PAUSE_CYC cycles after reset is released and rises in cycle PAUSE_CYC, where cycle n is the interval following the n-th rising edge after release.
- R3: After the pause, exactly INIT_REFS refreshes are performed before `init_done_o` rises. It rises one cycle after the engine returns to idle following the last of them, and it never falls again until reset.
- R4: A refresh starts only at a clock edge where `req_o` and `grant_i` are both 1. `own_o` rises in the cycle that follows that edge.
- R5: Each ownership begins with CAS and RAS high for T_SETUP cycles, the larger of the CAS precharge and write-enable setup counts. CAS is then low with RAS high for exactly T_CSR cycles before RAS falls.
- R6: RAS stays low for exactly T_RAS cycles with CAS low the whole time. CAS and RAS rise in the same cycle.
- R7: Between two chained refreshes, RAS and CAS are both high for exactly T_RP cycles before CAS falls again.
- R8: `we_n_o` is 1 in every cycle.
- R9: After `init_done_o`, the owed count rises by one every IVL_CYC cycles and falls by one when a refresh starts. `req_o` is 1 exactly while refreshes are owed, so with a grant that always answers the request, request rises are IVL_CYC cycles apart and each ownership carries one refresh.
- R10: The owed count saturates at MAX_OWED. After the grant has been withheld for more than MAX_OWED intervals, the next ownership carries at least MAX_OWED and fewer than MAX_OWED+4 refreshes.
- R11: When `req_o` and `grant_i` are both 1 on the edge that ends a precharge, the next refresh chains without releasing the bus. Otherwise `own_o` falls T_RP+1 cycles after RAS rises.
- R12: Whenever `own_o` is 0, `ras_n_o` and `cas_n_o` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Access controller hands the DRAM bus to this block |
| req_o | output | 1 | Refresh wanted (initial or owed) |
| own_o | output | 1 | This block is driving the RAS/CAS/WE strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| init_done_o | output | 1 | Power-up sequence complete, accesses allowed |

## Verification
A wrong owed count or phase shows up on `req_o` within one cycle. It also changes how many refreshes land in one ownership window, which is visible when that window closes. A miscounted strobe timer alters the RAS low width, the CAS lead, the precharge gap or the release cycle. Each of these shows in the first refresh after the fault, within about thirty cycles. The bench's cycle model compares every output on every clock, so any state divergence is reported in the cycle it reaches a port.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

   typedef enum logic [1:0] {
      PH_PAUSE,
      PH_INIT,
      PH_RUN
   } phase_e;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_PRE,
      ENG_CSR,
      ENG_RASLO,
      ENG_RP,
      ENG_REL
   } eng_state_e;

   // Round a nanosecond figure up to whole clock cycles (at least one).
   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_pace.sv
`timescale 1ns/1ps
// Power-up pause, initial refresh budget and periodic owed-refresh count.
module rfsh_pace
   import rfsh_pkg::*;
#(
   parameter int PAUSE_CYC = 50000,
   parameter int IVL_CYC   = 3906,
   parameter int INIT_REFS = 8,
   parameter int MAX_OWED  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic eng_idle_i,
   output logic req_o,
   output logic done_o
);

   localparam int PW = $clog2(PAUSE_CYC + 1);
   localparam int IW = $clog2(IVL_CYC + 1);
   localparam int NW = $clog2(INIT_REFS + 1);
   localparam int OW = $clog2(MAX_OWED + 1);

   phase_e        phase_q;
   logic [PW-1:0] pause_q;
   logic [IW-1:0] ivl_q;
   logic [NW-1:0] init_q;
   logic [OW-1:0] owed_q;
   logic          tick;
   logic          start_run;

   assign tick      = (phase_q == PH_RUN) && (ivl_q == '0);
   assign start_run = start_i && (phase_q == PH_RUN);

   // Phase sequencing: pause -> initial refreshes -> periodic operation.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PAUSE;
         pause_q <= PW'(PAUSE_CYC - 1);
         ivl_q   <= '0;
         init_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_PAUSE: begin
               if (pause_q == '0) begin
                  phase_q <= PH_INIT;
                  init_q  <= NW'(INIT_REFS);
               end else begin
                  pause_q <= pause_q - PW'(1);
               end
            end
            PH_INIT: begin
               if (start_i && (init_q != '0)) init_q <= init_q - NW'(1);
               if ((init_q == '0) && eng_idle_i) begin
                  phase_q <= PH_RUN;
                  ivl_q   <= IW'(IVL_CYC - 1);
               end
            end
            PH_RUN: begin
               ivl_q <= tick ? IW'(IVL_CYC - 1) : ivl_q - IW'(1);
            end
            default: phase_q <= PH_PAUSE;
         endcase
      end
   end

   // Owed refreshes, saturating at MAX_OWED.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else if (tick && !start_run) begin
         if (owed_q != OW'(MAX_OWED)) owed_q <= owed_q + OW'(1);
      end else if (!tick && start_run) begin
         owed_q <= owed_q - OW'(1);
      end
   end

   assign req_o  = ((phase_q == PH_INIT) && (init_q != '0)) ||
                   ((phase_q == PH_RUN)  && (owed_q != '0));
   assign done_o = (phase_q == PH_RUN);

endmodule

// File: rtl/rfsh_cbr_engine.sv
`timescale 1ns/1ps
// Strobe sequencer for one or more chained CAS-before-RAS cycles.
module rfsh_cbr_engine
   import rfsh_pkg::*;
#(
   parameter int T_SETUP  = 3,
   parameter int T_CSR    = 3,
   parameter int T_RAS    = 13,
   parameter int T_RP     = 8,
   parameter int CHAIN_EN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic grant_i,
   output logic start_o,
   output logic idle_o,
   output logic own_o,
   output logic ras_n_o,
   output logic cas_n_o
);

   localparam int T_MAX = max_int(max_int(T_SETUP, T_CSR), max_int(T_RAS, T_RP));
   localparam int CW    = $clog2(T_MAX + 1);

   eng_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          cnt_zero;
   logic          take;
   logic          chain_ok;
   logic          ras_n_q, cas_n_q, own_q;

   assign cnt_zero = (cnt_q == '0);
   assign take     = req_i && grant_i;

   generate
      if (CHAIN_EN != 0) begin : g_chain
         assign chain_ok = take;
      end else begin : g_no_chain
         assign chain_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_zero ? cnt_q : cnt_q - CW'(1);
      start_o = 1'b0;
      unique case (st_q)
         ENG_IDLE: begin
            if (take) begin
               st_d    = ENG_PRE;
               cnt_d   = CW'(T_SETUP - 1);
               start_o = 1'b1;
            end
         end
         ENG_PRE: begin
            if (cnt_zero) begin
               st_d  = ENG_CSR;
               cnt_d = CW'(T_CSR - 1);
            end
         end
         ENG_CSR: begin
            if (cnt_zero) begin
               st_d  = ENG_RASLO;
               cnt_d = CW'(T_RAS - 1);
            end
         end
         ENG_RASLO: begin
            if (cnt_zero) begin
               st_d  = ENG_RP;
               cnt_d = CW'(T_RP - 1);
            end
         end
         ENG_RP: begin
            if (cnt_zero) begin
               if (chain_ok) begin
                  st_d    = ENG_CSR;
                  cnt_d   = CW'(T_CSR - 1);
                  start_o = 1'b1;
               end else begin
                  st_d = ENG_REL;
               end
            end
         end
         ENG_REL: st_d = ENG_IDLE;
         default: st_d = ENG_IDLE;
      endcase
   end

   // Strobes are registered from the next state so they never glitch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ENG_IDLE;
         cnt_q   <= '0;
         ras_n_q <= 1'b1;
         cas_n_q <= 1'b1;
         own_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         ras_n_q <= (st_d != ENG_RASLO);
         cas_n_q <= !((st_d == ENG_CSR) || (st_d == ENG_RASLO));
         own_q   <= (st_d != ENG_IDLE);
      end
   end

   assign idle_o  = (st_q == ENG_IDLE);
   assign own_o   = own_q;
   assign ras_n_o = ras_n_q;
   assign cas_n_o = cas_n_q;

endmodule

// File: rtl/rfsh_sched.sv
`timescale 1ns/1ps
// CAS-before-RAS refresh scheduler: top level.
module rfsh_sched
   import rfsh_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int PAUSE_NS      = 200000,
   parameter int REF_WINDOW_NS = 64000000,
   parameter int REF_ROWS      = 4096,
   parameter int T_CSR_NS      = 10,
   parameter int T_CHR_NS      = 10,
   parameter int T_RPC_NS      = 5,
   parameter int T_WRP_NS      = 10,
   parameter int T_RAS_NS      = 50,
   parameter int T_RP_NS       = 30,
   parameter int INIT_REFS     = 8,
   parameter int MAX_OWED      = 8,
   parameter int CHAIN_EN      = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   output logic req_o,
   output logic own_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic init_done_o
);

   localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PERIOD_PS);
   localparam int IVL_CYC   = ((REF_WINDOW_NS / REF_ROWS) * 1000) / CLK_PERIOD_PS;
   localparam int T_CSR_CYC = ns_to_cyc(T_CSR_NS, CLK_PERIOD_PS);
   localparam int T_CHR_CYC = ns_to_cyc(T_CHR_NS, CLK_PERIOD_PS);
   localparam int T_RPC_CYC = ns_to_cyc(T_RPC_NS, CLK_PERIOD_PS);
   localparam int T_WRP_CYC = ns_to_cyc(T_WRP_NS, CLK_PERIOD_PS);
   localparam int T_RAS_CYC = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
   localparam int T_RP_CYC  = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
   localparam int T_SET_CYC = max_int(T_RPC_CYC, T_WRP_CYC);

   initial begin : param_checks
      if (IVL_CYC < 1)
         $fatal(1, "refresh interval shorter than one clock");
      if (INIT_REFS < 1 || MAX_OWED < 1)
         $fatal(1, "refresh counts must be positive");
      if (T_CHR_CYC > T_RAS_CYC)
         $fatal(1, "CAS hold after RAS fall exceeds RAS low width");
      if (CHAIN_EN != 0 && (T_RP_CYC < max_int(T_RPC_CYC, T_WRP_CYC)))
         $fatal(1, "chained precharge shorter than CAS/WE setup");
   end

   logic start;
   logic eng_idle;

   rfsh_pace #(
      .PAUSE_CYC (PAUSE_CYC),
      .IVL_CYC   (IVL_CYC),
      .INIT_REFS (INIT_REFS),
      .MAX_OWED  (MAX_OWED)
   ) u_pace (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .eng_idle_i (eng_idle),
      .req_o      (req_o),
      .done_o     (init_done_o)
   );

   rfsh_cbr_engine #(
      .T_SETUP  (T_SET_CYC),
      .T_CSR    (T_CSR_CYC),
      .T_RAS    (T_RAS_CYC),
      .T_RP     (T_RP_CYC),
      .CHAIN_EN (CHAIN_EN)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_o),
      .grant_i (grant_i),
      .start_o (start),
      .idle_o  (eng_idle),
      .own_o   (own_o),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o)
   );

   // Write enable stays high so a refresh never enters the test state.
   assign we_n_o = 1'b1;

endmodule

// File: rtl/rfsh_sched_chk.sv
`timescale 1ns/1ps
module rfsh_sched_chk #(
   parameter int T_CSR     = 3,
   parameter int T_RAS     = 13,
   parameter int T_RP      = 8,
   parameter int PAUSE_CYC = 1,
   parameter int INIT_REFS = 8
) (
   input logic clk,
   input logic rst_n,
   input logic grant_i,
   input logic req_o,
   input logic own_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic init_done_o
);

   logic [31:0] since_rst;
   logic [15:0] csr_run, ras_lo, ras_hi, falls;
   logic        ras_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         csr_run   <= '0;
         ras_lo    <= '0;
         ras_hi    <= '0;
         falls     <= '0;
         ras_prev  <= 1'b1;
      end else begin
         if (since_rst != '1) since_rst <= since_rst + 32'd1;
         ras_prev <= ras_n_o;
         if (!ras_n_o && ras_prev && (falls != '1)) falls <= falls + 16'd1;
         if (cas_n_o) csr_run <= '0;
         else if (ras_n_o && (csr_run != '1)) csr_run <= csr_run + 16'd1;
         if (ras_n_o) begin
            ras_lo <= '0;
            if (ras_hi != '1) ras_hi <= ras_hi + 16'd1;
         end else begin
            ras_hi <= '0;
            if (ras_lo != '1) ras_lo <= ras_lo + 16'd1;
         end
      end
   end

   assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 32'(PAUSE_CYC)) |-> !req_o);

   assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |=> init_done_o);

   assert_init_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done_o) |-> (falls >= 16'(INIT_REFS)));

   assert_grant_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_o) |-> $past(grant_i && req_o));

   assert_cas_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (csr_run == 16'(T_CSR)));

   assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> (ras_lo == 16'(T_RAS)));

   assert_cas_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_o |-> !cas_n_o);

   assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (ras_hi >= 16'(T_RP)));

   assert_idle_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !own_o |-> (ras_n_o && cas_n_o));

endmodule

bind rfsh_sched rfsh_sched_chk #(
   .T_CSR     (T_CSR_CYC),
   .T_RAS     (T_RAS_CYC),
   .T_RP      (T_RP_CYC),
   .PAUSE_CYC (PAUSE_CYC),
   .INIT_REFS (INIT_REFS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .grant_i     (grant_i),
   .req_o       (req_o),
   .own_o       (own_o),
   .ras_n_o     (ras_n_o),
   .cas_n_o     (cas_n_o),
   .init_done_o (init_done_o)
);

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
module rfsh_sched_tb;

   // Expected cycle counts at 4 ns, rounded up from the nanosecond figures.
   localparam int E_PAUSE = (400 * 1000 + 3999) / 4000;       // 100
   localparam int E_IVL   = (400 * 1000) / 4000;              // 100
   localparam int E_CSR   = (10 * 1000 + 3999) / 4000;        // 3
   localparam int E_SET   = (10 * 1000 + 3999) / 4000;        // 3 (larger of 5 and 10 ns)
   localparam int E_RAS   = (50 * 1000 + 3999) / 4000;        // 13
   localparam int E_RP    = (30 * 1000 + 3999) / 4000;        // 8
   localparam int E_INIT  = 8;
   localparam int E_MAXO  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant = 1'b0;
   logic req, own, ras_n, cas_n, we_n, done;

   rfsh_sched #(
      .CLK_PERIOD_PS (4000),
      .PAUSE_NS      (400),
      .REF_WINDOW_NS (1638400)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_i     (grant),
      .req_o       (req),
      .own_o       (own),
      .ras_n_o     (ras_n),
      .cas_n_o     (cas_n),
      .we_n_o      (we_n),
      .init_done_o (done)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   bit follow  = 1'b0;
   bit started = 1'b0;
   bit measure = 1'b0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // Controller stand-in: answers the request when following is enabled.
   always @(negedge clk) grant <= follow & req;

   // Watchdog.
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_err++;
         $display("FAIL R4 watchdog actual=%0d expected=finish", cyc);
         summary();
         $finish;
      end
   end

   // ---------------- reference model ----------------
   int m_phase, m_pause, m_init, m_owed, m_ivl, m_st, m_cnt;

   function automatic bit m_req();
      return (m_phase == 1 && m_init > 0) || (m_phase == 2 && m_owed > 0);
   endfunction

   always @(posedge clk) begin
      bit rq, tk, go;
      int nst, ncnt;
      if (!rst_n) begin
         m_phase = 0; m_pause = E_PAUSE - 1; m_init = 0;
         m_owed = 0; m_ivl = 0; m_st = 0; m_cnt = 0;
      end else begin
         rq = m_req();
         go = 1'b0;
         nst = m_st;
         ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
         case (m_st)
            0: if (rq && grant) begin nst = 1; ncnt = E_SET - 1; go = 1'b1; end
            1: if (m_cnt == 0) begin nst = 2; ncnt = E_CSR - 1; end
            2: if (m_cnt == 0) begin nst = 3; ncnt = E_RAS - 1; end
            3: if (m_cnt == 0) begin nst = 4; ncnt = E_RP - 1; end
            4: if (m_cnt == 0) begin
                  if (rq && grant) begin nst = 2; ncnt = E_CSR - 1; go = 1'b1; end
                  else nst = 5;
               end
            default: nst = 0;
         endcase
         case (m_phase)
            0: if (m_pause == 0) begin m_phase = 1; m_init = E_INIT; end
               else m_pause--;
            1: begin
                  if (m_init == 0 && m_st == 0) begin m_phase = 2; m_ivl = E_IVL - 1; end
                  else if (go) m_init--;
               end
            default: begin
                  tk = (m_ivl == 0);
                  m_ivl = tk ? E_IVL - 1 : m_ivl - 1;
                  m_owed = m_owed + int'(tk) - int'(go);
                  if (m_owed > E_MAXO) m_owed = E_MAXO;
               end
         endcase
         m_st = nst;
         m_cnt = ncnt;
      end
   end

   // ---------------- per-cycle compare and waveform monitors ----------------
   int ras_lo_run = 0, csr_run = 0, cas_hi_run = 0, win_falls = 0;
   int falls_total = 0, last_win = 0, win_idx = 0, last_rise = -1, gaps = 0;
   bit first_in_own = 1'b0, p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b0, p_req = 1'b0;

   always @(negedge clk) begin
      if (started) begin
         check("R9 req_o vs model", int'(req), int'(m_req()));
         check("R4 own_o vs model", int'(own), int'(m_st != 0));
         check("R6 ras_n_o vs model", int'(ras_n), int'(m_st != 3));
         check("R5 cas_n_o vs model", int'(cas_n), int'(!(m_st == 2 || m_st == 3)));
         check("R3 init_done_o vs model", int'(done), int'(m_phase == 2));
         check("R8 we_n_o high", int'(we_n), 1);
         if (!own) check("R12 strobes high while not owning", int'(ras_n && cas_n), 1);

         if (own && !p_own) begin
            first_in_own = 1'b1;
            cas_hi_run = 0;
            win_falls = 0;
         end
         if (own && cas_n) cas_hi_run++;
         if (!cas_n && p_cas) begin
            if (first_in_own) check("R5 CAS high at ownership start", cas_hi_run, E_SET);
            else              check("R7 chained precharge length", cas_hi_run, E_RP);
            first_in_own = 1'b0;
            cas_hi_run = 0;
         end
         if (!cas_n && ras_n) csr_run++;
         if (!ras_n && p_ras) begin
            check("R5 CAS lead before RAS fall", csr_run, E_CSR);
            csr_run = 0;
            win_falls++;
            falls_total++;
         end
         if (!ras_n) ras_lo_run++;
         if (ras_n && !p_ras) begin
            check("R6 RAS low width", ras_lo_run, E_RAS);
            check("R6 CAS rises with RAS", int'(cas_n), 1);
            ras_lo_run = 0;
         end
         if (!own && p_own) begin
            check("R11 release after final precharge", cas_hi_run, E_RP + 1);
            if (measure) check("R9 one refresh per ownership", win_falls, 1);
            last_win = win_falls;
            win_idx++;
         end
         if (measure && req && !p_req) begin
            if (last_rise >= 0) begin
               check("R9 request spacing", cyc - last_rise, E_IVL);
               gaps++;
            end
            last_rise = cyc;
         end
      end
      p_ras = ras_n; p_cas = cas_n; p_own = own; p_req = req;
   end

   // ---------------- stimulus ----------------
   initial begin
      int idx0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 req_o in reset", int'(req), 0);
      check("R1 own_o in reset", int'(own), 0);
      check("R1 ras_n_o in reset", int'(ras_n), 1);
      check("R1 cas_n_o in reset", int'(cas_n), 1);
      check("R1 we_n_o in reset", int'(we_n), 1);
      check("R1 init_done_o in reset", int'(done), 0);
      rst_n = 1'b1;
      started = 1'b1;
      follow = 1'b1;

      repeat (E_PAUSE - 1) @(posedge clk);
      @(negedge clk);
      check("R2 request quiet at end of pause", int'(req), 0);
      @(posedge clk);
      @(negedge clk);
      check("R2 request raised after pause", int'(req), 1);

      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      check("R3 init_done reached", int'(done), 1);
      check("R3 initial refresh count", falls_total, E_INIT);

      last_rise = -1;
      gaps = 0;
      measure = 1'b1;
      repeat (800) @(negedge clk);
      measure = 1'b0;
      check("R9 periodic requests observed", int'(gaps >= 5), 1);

      // Withhold the grant long enough to saturate the owed count.
      follow = 1'b0;
      repeat (1200) @(negedge clk);
      check("R10 request held while owed", int'(req), 1);
      check("R4 no ownership without grant", int'(own), 0);

      idx0 = win_idx;
      follow = 1'b1;
      for (int i = 0; i < 4000 && win_idx == idx0; i++) @(negedge clk);
      check("R10 burst at least saturation", int'(last_win >= E_MAXO), 1);
      check("R10 burst bounded by saturation", int'(last_win < E_MAXO + 4), 1);
      check("R11 refreshes chained in one ownership", int'(last_win >= 2), 1);

      repeat (400) @(negedge clk);
      check("R3 init_done still high", int'(done), 1);
      summary();
      $finish;
   end

endmodule